// File: doc/BRIEF.md
# Quantized Convolution Processing Element

This block is the arithmetic core of an 8-bit fixed-point CNN inference engine. Each accepted input beat carries one 3x3 window of signed 8-bit activations and one 3x3 set of signed 8-bit weights for every input channel, plus one signed 8-bit bias. One 3x3 multiply-accumulate unit per channel forms a dot product. An adder tree merges those channel sums with the bias, which is first shifted left into the accumulator's binary-point position. The result then passes through a rounding right shift that brings it back to 8 bits, an optional rectifier and an optional 2x2 max pool. Only the final value leaves the block, on a one-word write port toward the output buffer.

The accumulator's binary point moves from layer to layer, so the layer controller sets two shift amounts: one for the bias and one for the output. A per-layer stride thins the stream of windows along each image line. The output buffer can raise a stall line at any time. Stall freezes every stage in place and refuses new windows, so no result is lost or duplicated.

Top module: `qconv_pe`

## Requirements
- R1: For each channel c (0..3), pixel and weight tap k (0..8, row-major in the 3x3 window) sit at bits [(c*9+k)*8 +: 8] of `in_pix` and `in_wgt`. Each convolver forms the signed sum of the nine pixel-by-weight products of its channel.
- R2: The adder tree adds the four channel sums to the signed bias shifted left by `cfg_bias_shift` (0..15).
- R3: The accumulator is 24 bits wide. It holds the exact sum for every combination of 8-bit inputs and bias shifts, including all operands at -128 with bias 127 shifted by 15.
- R4: The output stage computes (acc + 2^(s-1)) >> s arithmetically, with s = `cfg_out_shift` and no rounding term when s is 0. It then saturates the result to [-128, 127].
- R5: When `cfg_relu_en` is 1, negative quantized values become 0. When it is 0, they pass through unchanged.
- R6: When `cfg_pool_en` is 1, the block emits one result for every four consecutive quantized values, equal to their maximum. When it is 0, every value is emitted and the group count is cleared.
- R7: Within a line, windows are numbered from the one flagged by `in_sol` (index 0). Only windows whose index is a multiple of the stride (`cfg_stride`, where 0 means 1) are computed. The others are discarded.
- R8: With pooling bypassed and no stall, the result of a window accepted at a clock edge shows on `out_valid`/`out_data` after the fifth edge from that one.
- R9: While `stall` is 1, no window is accepted and `out_valid`/`out_data` hold their values. Every computed result is eventually delivered exactly once, in order, at an edge where `stall` is 0.
- R10: During and after reset, `out_valid` and `out_data` are 0 until a result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stall | input | 1 | Output buffer busy: freeze the pipeline and refuse windows |
| in_valid | input | 1 | A window is presented |
| in_sol | input | 1 | This window is the first of an image line |
| in_pix | input | 288 | Four channels of 3x3 signed 8-bit activations |
| in_wgt | input | 288 | Four channels of 3x3 signed 8-bit weights |
| in_bias | input | 8 | Signed bias for this output |
| cfg_stride | input | 2 | Convolution stride, 0 treated as 1 |
| cfg_bias_shift | input | 4 | Left shift applied to the bias |
| cfg_out_shift | input | 4 | Rounding right shift applied to the sum |
| cfg_relu_en | input | 1 | Enable the rectifier |
| cfg_pool_en | input | 1 | Enable 4-to-1 max pooling |
| out_valid | output | 1 | A result is on out_data |
| out_data | output | 8 | Signed 8-bit result |

## Verification
Each pattern targets a specific corner case and the failure it would expose:
- **Rounding ties with both signs.** A design that truncates, or rounds negative ties away from zero, returns -2 instead of -1 for -3 shifted by one.
- **Largest possible sums.** An accumulator that is too narrow wraps, so a result that should saturate to 127 or -128 comes out with the wrong sign.
- **Strides of 2, 3 and the zero code, with line starts at random places.** A stride counter that ignores the line flag, or mishandles the zero code, yields results for the wrong windows.
- **Random stall against random window gaps.** A stage that keeps moving under stall drops a result or sends one twice. A held output that changes value is caught on the very next cycle.
- **Pooling over both positive and negative groups.** A maximum that starts from zero instead of from the first member gives 0 in place of a negative maximum.

// File: rtl/qpe_pkg.sv
package qpe_pkg;
  localparam int QPE_DW    = 8;   // activation and weight width
  localparam int QPE_NCH   = 4;   // parallel input channels
  localparam int QPE_KDIM  = 3;   // kernel edge
  localparam int QPE_ACCW  = 24;  // accumulator width
  localparam int QPE_SHW   = 4;   // shift amount field width
  localparam int QPE_POOLN = 4;   // values merged by one pool output
endpackage

// File: rtl/qpe_conv.sv
module qpe_conv #(
  parameter int DW   = 8,
  parameter int TAPS = 9,
  parameter int SW   = 2 * DW + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [TAPS*DW-1:0]   i_pix,
  input  logic [TAPS*DW-1:0]   i_wgt,
  output logic signed [SW-1:0] o_sum
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod_d [TAPS];
  logic signed [PW-1:0] prod_q [TAPS];
  logic signed [SW-1:0] sum_d;
  logic signed [SW-1:0] sum_q;

  // stage 1: one product per tap
  always_comb begin
    for (int k = 0; k < TAPS; k++) begin
      prod_d[k] = $signed(i_pix[k*DW +: DW]) * $signed(i_wgt[k*DW +: DW]);
    end
  end

  // stage 2: reduce the nine products
  always_comb begin
    sum_d = '0;
    for (int k = 0; k < TAPS; k++) begin
      sum_d = sum_d + SW'(prod_q[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) prod_q[k] <= '0;
      sum_q <= '0;
    end else if (en) begin
      for (int k = 0; k < TAPS; k++) prod_q[k] <= prod_d[k];
      sum_q <= sum_d;
    end
  end

  assign o_sum = sum_q;
endmodule

// File: rtl/qpe_post.sv
module qpe_post #(
  parameter int DW   = 8,
  parameter int NCH  = 4,
  parameter int TAPS = 9,
  parameter int SW   = 20,
  parameter int ACCW = 24,
  parameter int SHW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [SHW-1:0]     cfg_bsh,
  input  logic [SHW-1:0]     cfg_osh,
  input  logic               cfg_relu,
  input  logic               i_valid,
  input  logic [NCH*SW-1:0]  i_sums,
  input  logic [DW-1:0]      i_bias,
  output logic               o_valid,
  output logic [DW-1:0]      o_data
);
  localparam logic signed [ACCW:0] QMAX = (ACCW+1)'((1 << (DW-1)) - 1);
  localparam logic signed [ACCW:0] QMIN = -QMAX - 1;
  localparam longint ACC_LIM = longint'(NCH) * TAPS * (longint'(1) << (2*DW-2))
                             + (longint'(1) << (DW - 1 + (1 << SHW) - 1));

  logic signed [ACCW-1:0] acc_d, acc_q;
  logic                   accv_q;
  logic signed [ACCW:0]   rnd, rsum, shd;
  logic signed [DW-1:0]   q_d, q_q;
  logic                   qv_q;

  // adder tree plus aligned bias
  always_comb begin
    acc_d = ACCW'($signed(i_bias)) <<< cfg_bsh;
    for (int c = 0; c < NCH; c++) begin
      acc_d = acc_d + ACCW'($signed(i_sums[c*SW +: SW]));
    end
  end

  // rounding shift, saturation, rectifier
  always_comb begin
    rnd  = (cfg_osh == '0) ? '0 : ((ACCW+1)'(1) << (cfg_osh - 1'b1));
    rsum = {acc_q[ACCW-1], acc_q} + rnd;
    shd  = rsum >>> cfg_osh;
    if (shd > QMAX)      q_d = QMAX[DW-1:0];
    else if (shd < QMIN) q_d = QMIN[DW-1:0];
    else                 q_d = shd[DW-1:0];
    if (cfg_relu && q_d[DW-1]) q_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      accv_q <= 1'b0;
      q_q    <= '0;
      qv_q   <= 1'b0;
    end else if (en) begin
      acc_q  <= acc_d;
      accv_q <= i_valid;
      q_q    <= q_d;
      qv_q   <= accv_q;
    end
  end

  assign o_valid = qv_q;
  assign o_data  = q_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    accv_q |-> (longint'(acc_q) <= ACC_LIM) && (longint'(acc_q) >= -ACC_LIM)); // R3

  AST_VALID_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    en && i_valid |=> accv_q); // R8
endmodule

// File: rtl/qpe_pool.sv
module qpe_pool #(
  parameter int DW    = 8,
  parameter int POOLN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pool_en,
  input  logic          i_valid,
  input  logic [DW-1:0] i_data,
  output logic          o_valid,
  output logic [DW-1:0] o_data
);
  localparam int CW = $clog2(POOLN);
  localparam logic [CW-1:0] LAST = CW'(POOLN - 1);

  logic [CW-1:0]        cnt_d, cnt_q;
  logic signed [DW-1:0] max_d, max_q, cur;
  logic                 ov_d, ov_q;
  logic [DW-1:0]        od_d, od_q;

  always_comb begin
    cnt_d = cnt_q;
    max_d = max_q;
    ov_d  = 1'b0;
    od_d  = od_q;
    cur   = $signed(i_data);
    if (!pool_en) begin
      cnt_d = '0;
      ov_d  = i_valid;
      if (i_valid) od_d = i_data;
    end else if (i_valid) begin
      if (cnt_q != '0 && max_q > $signed(i_data)) cur = max_q;
      if (cnt_q == LAST) begin
        ov_d  = 1'b1;
        od_d  = cur;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        max_d = cur;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      max_q <= '0;
      ov_q  <= 1'b0;
      od_q  <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
      max_q <= max_d;
      ov_q  <= ov_d;
      od_q  <= od_d;
    end
  end

  assign o_valid = ov_q;
  assign o_data  = od_q;

  AST_POOL_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    en && o_valid && pool_en && $past(pool_en) |=> !o_valid); // R6
endmodule

// File: rtl/qconv_pe.sv
module qconv_pe
  import qpe_pkg::*;
#(
  parameter int DW    = QPE_DW,
  parameter int NCH   = QPE_NCH,
  parameter int KDIM  = QPE_KDIM,
  parameter int ACCW  = QPE_ACCW,
  parameter int SHW   = QPE_SHW,
  parameter int POOLN = QPE_POOLN
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       stall,
  input  logic                       in_valid,
  input  logic                       in_sol,
  input  logic [NCH*KDIM*KDIM*DW-1:0] in_pix,
  input  logic [NCH*KDIM*KDIM*DW-1:0] in_wgt,
  input  logic [DW-1:0]              in_bias,
  input  logic [1:0]                 cfg_stride,
  input  logic [SHW-1:0]             cfg_bias_shift,
  input  logic [SHW-1:0]             cfg_out_shift,
  input  logic                       cfg_relu_en,
  input  logic                       cfg_pool_en,
  output logic                       out_valid,
  output logic [DW-1:0]              out_data
);
  localparam int TAPS = KDIM * KDIM;
  localparam int SW   = 2 * DW + $clog2(TAPS);

  logic [1:0]        rs_q;
  logic              rst_ni;
  logic              en;
  logic [1:0]        stride_eff, phase_use, phase_d, phase_q;
  logic              take;
  logic              v1_d, v1_q, v2_q;
  logic [DW-1:0]     b1_q, b2_q;
  logic [NCH*SW-1:0] sums;
  logic              qv;
  logic [DW-1:0]     qd;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];
  assign en     = ~stall;

  // stride selection along a line
  always_comb begin
    stride_eff = (cfg_stride == 2'd0) ? 2'd1 : cfg_stride;
    phase_use  = in_sol ? 2'd0 : phase_q;
    take       = (phase_use == 2'd0);
    phase_d    = phase_q;
    if (in_valid && en) begin
      phase_d = (phase_use >= stride_eff - 2'd1) ? 2'd0 : phase_use + 2'd1;
    end
    v1_d = in_valid && take;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 2'd0;
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      b1_q    <= '0;
      b2_q    <= '0;
    end else if (en) begin
      phase_q <= phase_d;
      v1_q    <= v1_d;
      v2_q    <= v1_q;
      b1_q    <= in_bias;
      b2_q    <= b1_q;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_conv
    qpe_conv #(.DW(DW), .TAPS(TAPS), .SW(SW)) u_conv (
      .clk   (clk),
      .rst_n (rst_ni),
      .en    (en),
      .i_pix (in_pix[c*TAPS*DW +: TAPS*DW]),
      .i_wgt (in_wgt[c*TAPS*DW +: TAPS*DW]),
      .o_sum (sums[c*SW +: SW])
    );
  end

  qpe_post #(.DW(DW), .NCH(NCH), .TAPS(TAPS), .SW(SW), .ACCW(ACCW), .SHW(SHW)) u_post (
    .clk      (clk),
    .rst_n    (rst_ni),
    .en       (en),
    .cfg_bsh  (cfg_bias_shift),
    .cfg_osh  (cfg_out_shift),
    .cfg_relu (cfg_relu_en),
    .i_valid  (v2_q),
    .i_sums   (sums),
    .i_bias   (b2_q),
    .o_valid  (qv),
    .o_data   (qd)
  );

  qpe_pool #(.DW(DW), .POOLN(POOLN)) u_pool (
    .clk     (clk),
    .rst_n   (rst_ni),
    .en      (en),
    .pool_en (cfg_pool_en),
    .i_valid (qv),
    .i_data  (qd),
    .o_valid (out_valid),
    .o_data  (out_data)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    stall && out_valid |=> out_valid && $stable(out_data)); // R9

  AST_STRIDE_SKIP: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid && !stall && !in_sol && phase_q != 2'd0 |=> !v1_q); // R7

  AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && cfg_relu_en && $stable(cfg_relu_en) |-> !out_data[DW-1]); // R5
endmodule

// File: tb/sim_qconv_pe.sv
module sim_qconv_pe;
  localparam int NCH = 4;
  localparam int TAPS = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0, in_valid = 1'b0, in_sol = 1'b0;
  logic [NCH*TAPS*8-1:0] in_pix = '0, in_wgt = '0;
  logic [7:0] in_bias = '0;
  logic [1:0] cfg_stride = 2'd1;
  logic [3:0] cfg_bias_shift = '0, cfg_out_shift = '0;
  logic cfg_relu_en = 1'b0, cfg_pool_en = 1'b0;
  logic out_valid;
  logic [7:0] out_data;

  qconv_pe u0 (.*);

  always #10 clk = ~clk;  // 50 MHz

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  int pix [NCH][TAPS];
  int wgt [NCH][TAPS];
  int bias = 0;
  int expq [$];
  int ph = 0, pcnt = 0, pmax = 0, taken = 0;
  bit prev_st = 0, prev_ov = 0;
  logic [7:0] prev_d = '0;
  string tag = "R1";

  task automatic check(input bit ok, input string t, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  function automatic void model_accept(input bit sol);
    int use_ph, seff;
    longint acc, r;
    int q;
    seff = (cfg_stride == 0) ? 1 : int'(cfg_stride);
    use_ph = sol ? 0 : ph;
    ph = (use_ph >= seff - 1) ? 0 : use_ph + 1;
    if (use_ph != 0) return;   // R7
    taken++;
    acc = longint'(bias) * (longint'(1) << cfg_bias_shift);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < TAPS; k++) acc += pix[c][k] * wgt[c][k];
    if (cfg_out_shift == 0) r = acc;
    else r = (acc + (longint'(1) << (cfg_out_shift - 1))) >>> cfg_out_shift;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    q = int'(r);
    if (cfg_relu_en && q < 0) q = 0;
    if (!cfg_pool_en) expq.push_back(q);
    else begin
      if (pcnt == 0 || q > pmax) pmax = q;
      pcnt++;
      if (pcnt == 4) begin expq.push_back(pmax); pcnt = 0; end
    end
  endfunction

  task automatic step(input bit v, input bit sol, input bit st);
    int e;
    if (prev_st && prev_ov)
      check(out_valid === 1'b1 && out_data === prev_d, "R9 hold",
            int'($signed(out_data)), int'($signed(prev_d)));
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < TAPS; k++) begin
        in_pix[(c*TAPS+k)*8 +: 8] = 8'(pix[c][k]);
        in_wgt[(c*TAPS+k)*8 +: 8] = 8'(wgt[c][k]);
      end
    in_bias = 8'(bias);
    in_valid = v; in_sol = sol; stall = st;
    if (v && !st) model_accept(sol);
    if (out_valid && !st) begin
      if (expq.size() == 0) check(1'b0, {tag, " unexpected"}, int'($signed(out_data)), 0);
      else begin
        e = expq.pop_front();
        check(int'($signed(out_data)) == e, tag, int'($signed(out_data)), e);
      end
    end
    prev_st = st; prev_ov = out_valid; prev_d = out_data;
    @(negedge clk);
  endtask

  task automatic fill(input bit full);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < TAPS; k++) begin
        pix[c][k] = full ? int'($urandom_range(0, 255)) - 128 : int'($urandom_range(0, 15)) - 8;
        wgt[c][k] = full ? int'($urandom_range(0, 255)) - 128 : int'($urandom_range(0, 15)) - 8;
      end
    bias = int'($urandom_range(0, 255)) - 128;
  endtask

  task automatic drain();
    for (int i = 0; i < 14; i++) step(1'b0, 1'b0, 1'b0);
    check(expq.size() == 0, {tag, " drain"}, expq.size(), 0);  // R9: nothing lost
  endtask

  task automatic phase(input string t, input int n, input int str, input int bsh,
                       input int osh, input bit relu, input bit pool, input bit full,
                       input int stall_pct);
    bit v, sol, st;
    tag = t;
    cfg_stride = 2'(str); cfg_bias_shift = 4'(bsh); cfg_out_shift = 4'(osh);
    cfg_relu_en = relu; cfg_pool_en = pool; pcnt = 0;
    taken = 0;
    while (taken < n) begin
      fill(full);
      v = ($urandom_range(0, 3) != 0);
      sol = ($urandom_range(0, 7) == 0);
      st = (int'($urandom_range(0, 99)) < stall_pct);
      step(v, sol, st);
    end
    drain();
  endtask

  task automatic one_tap(input int p, input int w, input int osh, input string t);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < TAPS; k++) begin pix[c][k] = 0; wgt[c][k] = 0; end
    pix[0][0] = p; wgt[0][0] = w; bias = 0;
    tag = t; cfg_out_shift = 4'(osh);
    step(1'b1, 1'b1, 1'b0);
    drain();
  endtask

  initial begin
    int lat;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < TAPS; k++) begin pix[c][k] = 0; wgt[c][k] = 0; end
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10 valid in reset", int'(out_valid), 0);
    check(out_data === 8'd0, "R10 data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0, "R10 valid after reset", int'(out_valid), 0);

    // R8 latency, R1 and R2 with all-ones window: 36 + (2<<1) = 40
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < TAPS; k++) begin pix[c][k] = 1; wgt[c][k] = 1; end
    bias = 2; cfg_bias_shift = 4'd1; tag = "R2";
    step(1'b1, 1'b1, 1'b0);
    lat = 1;
    while (!out_valid && lat < 20) begin step(1'b0, 1'b0, 1'b0); lat++; end
    check(lat == 5, "R8 latency", lat, 5);
    check(int'($signed(out_data)) == 40, "R2 value", int'($signed(out_data)), 40);
    drain();

    // R4 ties of both signs with shift 1
    one_tap(3, 1, 1, "R4 tie +");
    one_tap(-3, 1, 1, "R4 tie -");
    one_tap(-5, 1, 2, "R4 quarter");

    // R3 extremes
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < TAPS; k++) begin pix[c][k] = -128; wgt[c][k] = -128; end
    bias = 127; cfg_bias_shift = 4'd15; cfg_out_shift = 4'd15; tag = "R3 max";
    step(1'b1, 1'b1, 1'b0); drain();
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < TAPS; k++) wgt[c][k] = 127;
    bias = -128; cfg_out_shift = 4'd0; tag = "R3 min";
    step(1'b1, 1'b1, 1'b0); drain();
    cfg_out_shift = 4'd8; tag = "R3 min shifted";
    step(1'b1, 1'b1, 1'b0); drain();

    phase("R1 small", 60, 1, 2, 3, 0, 0, 0, 0);
    phase("R4 rounding", 80, 1, 3, 5, 0, 0, 1, 0);
    phase("R4 saturate", 60, 1, 0, 2, 0, 0, 1, 0);
    phase("R5 relu", 60, 1, 4, 6, 1, 0, 1, 0);
    phase("R6 pool", 80, 1, 4, 7, 0, 1, 1, 0);
    phase("R6 pool relu", 40, 1, 2, 4, 1, 1, 0, 20);
    phase("R7 stride2", 60, 2, 3, 5, 0, 0, 1, 0);
    phase("R7 stride3", 60, 3, 3, 5, 0, 0, 1, 0);
    phase("R7 stride0", 40, 0, 3, 5, 0, 0, 1, 0);
    phase("R9 stall", 150, 2, 5, 8, 0, 0, 1, 40);
    phase("R9 stall pool", 120, 1, 5, 8, 1, 1, 1, 50);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule